// File: doc/BRIEF.md
# Pin-Multiplexed General-Purpose I/O Port

This block is one general-purpose I/O port of a chip. Each pin has a direction bit and an output-data bit held in registers, plus a synchronized read path from the pad. Software reaches these through a small register bus. One write strobe loads all direction bits at once and another loads all output-data bits. Three read strobes select what appears on the read-data bus: the direction bits, the output-data bits or the synchronized pad levels.

Every pin also has four override pairs, each an enable bit and a value bit. On-chip peripherals drive them to take the pin's pull-up, driver enable, driven value or digital input enable away from the registers. The overrides act through combinational logic only, so they steer the pad in the same cycle they change. A port-wide pull-up disable and a sleep signal are shared with the other ports. The ungated-by-synchronizer digital input goes out to peripherals directly. A pin claimed as a clock pin reads back as zero in every register view.

Top module: `pinmux_port`

## Requirements
- R1: While reset is asserted and after it is released, with no write and no override active, the direction and output-data registers hold 0, so every `pad_oe`, `pad_out` and `pad_pu` bit is 0.
- R2: With a pin's pull-up override enable low, its `pad_pu` is 1 exactly when its direction bit is 0, its output-data bit is 1 and `pu_disable` is 0.
- R3: With a pin's pull-up override enable high, its `pad_pu` equals its pull-up override value, whatever the direction bit, output-data bit and `pu_disable`.
- R4: A pin's `pad_oe` equals its driver override value when the driver override enable is high, and its direction bit otherwise.
- R5: When `pad_oe` is 1, `pad_out` is the value override value if the value override enable is high and the output-data bit otherwise; when `pad_oe` is 0, `pad_out` is 0.
- R6: A pin's input enable is its input override value when the input override enable is high, and the inverse of `sleep` otherwise; `raw_din` equals `pad_in` where the input is enabled and 0 where it is not, with no clock delay.
- R7: A write strobe (`wr_dir` or `wr_data`) loads all bits of `wr_value` into the addressed register at the next clock edge; no strobe leaves both registers unchanged.
- R8: `rd_value` is the bitwise OR of the direction bits when `rd_dir` is 1, the output-data bits when `rd_data` is 1, and the synchronized pad bits when `rd_pin` is 1; with no read strobe it is 0.
- R9: The synchronized pad bit read through `rd_pin` is the `raw_din` value from two clock edges earlier.
- R10: A bit set in `clk_claim` forces that bit of `rd_value` to 0 for all three read strobes.
- R11: A change on any override input, `pu_disable` or `sleep` reaches `pad_oe`, `pad_out`, `pad_pu` and `raw_din` within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_value | input | N_PINS | Write data for the register bus |
| wr_dir | input | 1 | Load direction register |
| wr_data | input | 1 | Load output-data register |
| rd_dir | input | 1 | Select direction bits for readback |
| rd_data | input | 1 | Select output-data bits for readback |
| rd_pin | input | 1 | Select synchronized pad bits for readback |
| rd_value | output | N_PINS | Read data |
| pu_disable | input | 1 | Port-wide pull-up disable |
| sleep | input | 1 | Sleep state, gates digital inputs |
| pad_in | input | N_PINS | Levels seen at the pads |
| pu_ov_en | input | N_PINS | Pull-up override enables |
| pu_ov_val | input | N_PINS | Pull-up override values |
| oe_ov_en | input | N_PINS | Driver-enable override enables |
| oe_ov_val | input | N_PINS | Driver-enable override values |
| dv_ov_en | input | N_PINS | Driven-value override enables |
| dv_ov_val | input | N_PINS | Driven-value override values |
| ie_ov_en | input | N_PINS | Input-enable override enables |
| ie_ov_val | input | N_PINS | Input-enable override values |
| clk_claim | input | N_PINS | Pins used as clock pins |
| pad_oe | output | N_PINS | Pad output-driver enables |
| pad_out | output | N_PINS | Pad driven values |
| pad_pu | output | N_PINS | Pad pull-up enables |
| raw_din | output | N_PINS | Gated, unsynchronized pad input for peripherals |

## Verification
The pad outputs and `raw_din` are combinational, so they are due in the cycle the overrides, `sleep` or `pu_disable` change, and one edge after a register write; `rd_value` for `rd_pin` is due two edges after the pad level changes. The bench drives inputs on the falling edge and compares every output at the following falling edge against a model whose registers and two-stage pad history advance on each rising edge, so every latency above is checked by construction of the model. For the same-cycle behaviour of R11, a directed phase changes overrides and compares the pad outputs one nanosecond later, before any clock edge.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

   // One pin's override bundle from the peripherals.
   typedef struct packed {
      logic pu_en;
      logic pu_val;
      logic oe_en;
      logic oe_val;
      logic dv_en;
      logic dv_val;
      logic ie_en;
      logic ie_val;
   } pin_ovr_t;

   // Per-pin pad controls produced by a pin cell.
   typedef struct packed {
      logic oe;
      logic dout;
      logic pu;
      logic ie;
   } pin_pad_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/pinmux_port_regs.sv
module pinmux_port_regs #(
   parameter int unsigned N_PINS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] wr_value,
   input  logic              wr_dir,
   input  logic              wr_data,
   output logic [N_PINS-1:0] dir_q,
   output logic [N_PINS-1:0] data_q
);

   initial begin
      if (N_PINS < 1) $error("pinmux_port_regs: N_PINS must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= '0;
         data_q <= '0;
      end else begin
         if (wr_dir)  dir_q  <= wr_value;
         if (wr_data) data_q <= wr_value;
      end
   end

   // R7
   hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_dir && !wr_data) |=> ($stable(dir_q) && $stable(data_q)));

   // R7
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (dir_q == $past(wr_value)));

endmodule

// File: rtl/pinmux_pin_cell.sv
module pinmux_pin_cell
   import pinmux_pkg::*;
(
   input  logic     dir_bit,
   input  logic     data_bit,
   input  logic     pu_disable,
   input  logic     sleep,
   input  logic     pad_level,
   input  pin_ovr_t ovr,
   output pin_pad_t pad,
   output logic     din_gated
);

   logic pu_native;
   logic oe_sel;
   logic dv_sel;
   logic ie_sel;

   always_comb begin
      // native pull-up: input pin, output-data bit high, not disabled port-wide
      pu_native = (~dir_bit) & data_bit & (~pu_disable);
      pad.pu    = ovr.pu_en ? ovr.pu_val : pu_native;

      oe_sel    = ovr.oe_en ? ovr.oe_val : dir_bit;
      pad.oe    = oe_sel;

      dv_sel    = ovr.dv_en ? ovr.dv_val : data_bit;
      pad.dout  = oe_sel & dv_sel;

      ie_sel    = ovr.ie_en ? ovr.ie_val : ~sleep;
      pad.ie    = ie_sel;

      // a disabled input is clamped low ahead of the synchronizer
      din_gated = pad_level & ie_sel;
   end

endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync
   import pinmux_pkg::*;
#(
   parameter int unsigned N_PINS = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] d,
   output logic [N_PINS-1:0] q
);

   initial begin
      if (STAGES < MIN_SYNC_STAGES) $error("pinmux_sync: STAGES below minimum");
      if (N_PINS < 1) $error("pinmux_sync: N_PINS must be at least 1");
   end

   logic [N_PINS-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pinmux_readback.sv
module pinmux_readback #(
   parameter int unsigned N_PINS = 8
) (
   input  logic [N_PINS-1:0] dir_q,
   input  logic [N_PINS-1:0] data_q,
   input  logic [N_PINS-1:0] pin_q,
   input  logic              rd_dir,
   input  logic              rd_data,
   input  logic              rd_pin,
   input  logic [N_PINS-1:0] clk_claim,
   output logic [N_PINS-1:0] rd_value
);

   logic [N_PINS-1:0] merged;

   always_comb begin
      merged = '0;
      if (rd_dir)  merged = merged | dir_q;
      if (rd_data) merged = merged | data_q;
      if (rd_pin)  merged = merged | pin_q;
      rd_value = merged & ~clk_claim;
   end

endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
   import pinmux_pkg::*;
#(
   parameter int unsigned N_PINS      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] wr_value,
   input  logic              wr_dir,
   input  logic              wr_data,
   input  logic              rd_dir,
   input  logic              rd_data,
   input  logic              rd_pin,
   output logic [N_PINS-1:0] rd_value,
   input  logic              pu_disable,
   input  logic              sleep,
   input  logic [N_PINS-1:0] pad_in,
   input  logic [N_PINS-1:0] pu_ov_en,
   input  logic [N_PINS-1:0] pu_ov_val,
   input  logic [N_PINS-1:0] oe_ov_en,
   input  logic [N_PINS-1:0] oe_ov_val,
   input  logic [N_PINS-1:0] dv_ov_en,
   input  logic [N_PINS-1:0] dv_ov_val,
   input  logic [N_PINS-1:0] ie_ov_en,
   input  logic [N_PINS-1:0] ie_ov_val,
   input  logic [N_PINS-1:0] clk_claim,
   output logic [N_PINS-1:0] pad_oe,
   output logic [N_PINS-1:0] pad_out,
   output logic [N_PINS-1:0] pad_pu,
   output logic [N_PINS-1:0] raw_din
);

   localparam int unsigned CNT_W = $clog2(SYNC_STAGES + 1) + 1;

   initial begin
      if (N_PINS < 1)   $error("pinmux_port: N_PINS must be at least 1");
      if (N_PINS > 64)  $error("pinmux_port: N_PINS larger than a port allows");
      if (SYNC_STAGES < MIN_SYNC_STAGES) $error("pinmux_port: SYNC_STAGES below minimum");
   end

   logic [N_PINS-1:0] dir_q;
   logic [N_PINS-1:0] data_q;
   logic [N_PINS-1:0] pin_q;
   logic [N_PINS-1:0] gated;

   pinmux_port_regs #(.N_PINS(N_PINS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_value (wr_value),
      .wr_dir   (wr_dir),
      .wr_data  (wr_data),
      .dir_q    (dir_q),
      .data_q   (data_q)
   );

   generate
      for (genvar p = 0; p < N_PINS; p++) begin : g_pin
         pin_ovr_t ovr;
         pin_pad_t pad;
         always_comb begin
            ovr.pu_en  = pu_ov_en[p];
            ovr.pu_val = pu_ov_val[p];
            ovr.oe_en  = oe_ov_en[p];
            ovr.oe_val = oe_ov_val[p];
            ovr.dv_en  = dv_ov_en[p];
            ovr.dv_val = dv_ov_val[p];
            ovr.ie_en  = ie_ov_en[p];
            ovr.ie_val = ie_ov_val[p];
         end
         pinmux_pin_cell u_cell (
            .dir_bit    (dir_q[p]),
            .data_bit   (data_q[p]),
            .pu_disable (pu_disable),
            .sleep      (sleep),
            .pad_level  (pad_in[p]),
            .ovr        (ovr),
            .pad        (pad),
            .din_gated  (gated[p])
         );
         assign pad_oe[p]  = pad.oe;
         assign pad_out[p] = pad.dout;
         assign pad_pu[p]  = pad.pu;
      end
   endgenerate

   assign raw_din = gated;

   pinmux_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (gated),
      .q     (pin_q)
   );

   pinmux_readback #(.N_PINS(N_PINS)) u_rb (
      .dir_q     (dir_q),
      .data_q    (data_q),
      .pin_q     (pin_q),
      .rd_dir    (rd_dir),
      .rd_data   (rd_data),
      .rd_pin    (rd_pin),
      .clk_claim (clk_claim),
      .rd_value  (rd_value)
   );

   // cycles since reset release, saturating; gates the history check below
   logic [CNT_W-1:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)                      since_rst <= '0;
      else if (since_rst < CNT_W'(SYNC_STAGES)) since_rst <= since_rst + 1'b1;
   end

   // R9
   pin_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pin && !rd_dir && !rd_data && SYNC_STAGES == 2 && since_rst >= CNT_W'(2))
      |-> ((rd_value ^ $past(raw_din, 2)) & ~clk_claim) == '0);

   // R10
   claim_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_value & clk_claim) == '0);

   // R6
   sleep_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep |-> (raw_din & ~ie_ov_en) == '0));

   // R4
   dir_drives_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> ((pad_oe ^ $past(wr_value)) & ~oe_ov_en) == '0);

   // R5
   undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      (!rst_n && oe_ov_en == '0 && pu_ov_en == '0) |=> (pad_oe == '0 && pad_pu == '0));

endmodule

// File: tb/test_pinmux_port.sv
`timescale 1ns/1ps
module test_pinmux_port;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] wr_value;
   logic         wr_dir, wr_data, rd_dir, rd_data, rd_pin;
   logic [N-1:0] rd_value;
   logic         pu_disable, sleep;
   logic [N-1:0] pad_in;
   logic [N-1:0] pu_ov_en, pu_ov_val, oe_ov_en, oe_ov_val;
   logic [N-1:0] dv_ov_en, dv_ov_val, ie_ov_en, ie_ov_val;
   logic [N-1:0] clk_claim;
   logic [N-1:0] pad_oe, pad_out, pad_pu, raw_din;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pinmux_port #(.N_PINS(N), .SYNC_STAGES(2)) i_pinmux_port (
      .clk(clk), .rst_n(rst_n), .wr_value(wr_value), .wr_dir(wr_dir), .wr_data(wr_data),
      .rd_dir(rd_dir), .rd_data(rd_data), .rd_pin(rd_pin), .rd_value(rd_value),
      .pu_disable(pu_disable), .sleep(sleep), .pad_in(pad_in),
      .pu_ov_en(pu_ov_en), .pu_ov_val(pu_ov_val), .oe_ov_en(oe_ov_en), .oe_ov_val(oe_ov_val),
      .dv_ov_en(dv_ov_en), .dv_ov_val(dv_ov_val), .ie_ov_en(ie_ov_en), .ie_ov_val(ie_ov_val),
      .clk_claim(clk_claim), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
      .raw_din(raw_din)
   );

   // ---- reference model state: registers and pad history ----
   logic [N-1:0] m_dir = '0, m_data = '0;
   logic [N-1:0] hist[$];

   function automatic logic [N-1:0] exp_raw();
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         bit en;
         en = ie_ov_en[i] ? ie_ov_val[i] : !sleep;
         r[i] = en ? pad_in[i] : 1'b0;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_dir  <= '0;
         m_data <= '0;
         hist = {'0, '0};
      end else begin
         if (wr_dir)  m_dir  <= wr_value;
         if (wr_data) m_data <= wr_value;
         hist.push_back(exp_raw());
         void'(hist.pop_front());
      end
   end

   task automatic cmp(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      logic [N-1:0] e_oe, e_out, e_pu, e_rd;
      for (int i = 0; i < N; i++) begin
         bit oe, v;
         oe = oe_ov_en[i] ? oe_ov_val[i] : m_dir[i];
         e_oe[i] = oe;
         v = dv_ov_en[i] ? dv_ov_val[i] : m_data[i];
         e_out[i] = oe && v;
         if (pu_ov_en[i]) e_pu[i] = pu_ov_val[i];
         else e_pu[i] = (m_dir[i] == 0) && (m_data[i] == 1) && (pu_disable == 0);
      end
      e_rd = '0;
      if (rd_dir)  e_rd |= m_dir;
      if (rd_data) e_rd |= m_data;
      if (rd_pin)  e_rd |= hist[0];
      e_rd &= ~clk_claim;
      cmp("R4 pad_oe", pad_oe, e_oe);
      cmp("R5 pad_out", pad_out, e_out);
      cmp("R2/R3 pad_pu", pad_pu, e_pu);
      cmp("R6 raw_din", raw_din, exp_raw());
      cmp("R8/R9/R10 rd_value", rd_value, e_rd);
   endtask

   // one cycle: compare at falling edge, then the caller drives new inputs
   task automatic tick();
      @(negedge clk);
      if (rst_n) check_all();
   endtask

   task automatic idle_inputs();
      wr_value = '0; wr_dir = 0; wr_data = 0;
      rd_dir = 0; rd_data = 0; rd_pin = 0;
      pu_disable = 0; sleep = 0; pad_in = '0;
      pu_ov_en = '0; pu_ov_val = '0; oe_ov_en = '0; oe_ov_val = '0;
      dv_ov_en = '0; dv_ov_val = '0; ie_ov_en = '0; ie_ov_val = '0;
      clk_claim = '0;
   endtask

   initial begin
      #(200000 * 20);
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      hist = {'0, '0};
      idle_inputs();
      rst_n = 0;
      pad_in = 8'hFF;
      wr_value = 8'hFF; wr_dir = 1; wr_data = 1;
      repeat (3) @(negedge clk);
      // R1: writes during reset are ignored; pads stay quiet
      cmp("R1 pad_oe in reset", pad_oe, '0);
      cmp("R1 pad_pu in reset", pad_pu, '0);
      idle_inputs();
      rst_n = 1;
      tick();
      rd_dir = 1; #1; cmp("R1 dir after reset", rd_value, '0);
      rd_dir = 0; rd_data = 1; #1; cmp("R1 data after reset", rd_value, '0);
      rd_data = 0;

      // R7: directed register writes
      wr_value = 8'hA5; wr_dir = 1; tick();
      wr_dir = 0; wr_value = 8'h3C; wr_data = 1; tick();
      wr_data = 0; wr_value = 8'hFF; rd_dir = 1; tick();   // no strobe: hold
      cmp("R7 dir held", rd_value, 8'hA5);
      rd_dir = 0; rd_data = 1; #1;
      cmp("R7 data held", rd_value, 8'h3C);
      // R2: dir=A5 data=3C -> pull-up where dir 0 and data 1 = 0x18
      cmp("R2 native pull-up", pad_pu, 8'h18);
      pu_disable = 1; #1;
      cmp("R2 pull-up disabled", pad_pu, 8'h00);
      // R3: override wins even with port-wide disable
      pu_ov_en = 8'h0F; pu_ov_val = 8'h05; #1;
      cmp("R3 pull-up override", pad_pu, 8'h05);
      tick();

      // R11: overrides act without a clock edge
      oe_ov_en = 8'hF0; oe_ov_val = 8'h50; #1;
      cmp("R11 oe override same cycle", pad_oe, 8'h55);
      dv_ov_en = 8'hFF; dv_ov_val = 8'h0F; #1;
      cmp("R11 value override same cycle", pad_out, 8'h05);
      sleep = 1; pad_in = 8'hFF; ie_ov_en = 8'h03; ie_ov_val = 8'h01; #1;
      cmp("R11 sleep clamp same cycle", raw_din, 8'h01);
      tick();

      // R9: pad step shows on readback after two edges
      idle_inputs(); rd_pin = 1; tick();
      pad_in = 8'hC3; tick();
      cmp("R9 one edge, old value", rd_value, 8'h00);
      tick();
      cmp("R9 two edges, new value", rd_value, 8'hC3);

      // R10: claimed pins read zero on every view
      clk_claim = 8'h81; rd_dir = 1; rd_data = 1; #1;
      cmp("R10 claimed pins zero", rd_value & 8'h81, 8'h00);
      tick();

      // random phase, model compared every cycle
      for (int c = 0; c < 3000; c++) begin
         wr_value = 8'($urandom); wr_dir = ($urandom % 4) == 0; wr_data = ($urandom % 4) == 0;
         rd_dir = $urandom % 2; rd_data = $urandom % 2; rd_pin = $urandom % 2;
         pu_disable = ($urandom % 4) == 0; sleep = ($urandom % 5) == 0;
         pad_in = 8'($urandom);
         pu_ov_en = 8'($urandom & $urandom); pu_ov_val = 8'($urandom);
         oe_ov_en = 8'($urandom & $urandom); oe_ov_val = 8'($urandom);
         dv_ov_en = 8'($urandom & $urandom); dv_ov_val = 8'($urandom);
         ie_ov_en = 8'($urandom & $urandom); ie_ov_val = 8'($urandom);
         clk_claim = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
         tick();
      end

      // mid-run reset: R1 again
      idle_inputs(); rst_n = 0; tick(); tick();
      rst_n = 1; tick();
      cmp("R1 pad_oe after second reset", pad_oe, 8'h00);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule